// File: doc/BRIEF.md
# Receive Baud Rate Strobe Generator

This block produces the sampling-rate enable for a serial receiver from the bus clock. A coarse prescaler with four fixed ratios is followed by a fixed divide-by-16 stage. The output of that stage then passes through one of two final dividers: a power-of-two divider picked by a 3-bit code, or an 8-bit programmable divider that takes over whenever its value is nonzero.

Every stage is a terminal-count counter that passes a one-cycle enable to the next, so the block has one clock domain and never creates a derived clock. The output is a registered single-cycle strobe. Software programs the block through a small write port. Any write to a mapped register restarts the whole divider chain, so the first strobe after a change comes one full new period after the write.

Top module: `rx_rate_gen`

## Requirements
- R1: After reset the control register and the extended register hold zero, `rate_stb_o` is low, and the strobe period is 16 bus clock cycles.
- R2: A write to address 0 loads the receiver rate code from data bits [2:0] and the coarse code from data bits [4:3]. Data bits [7:5] have no effect.
- R3: Receiver rate code c gives a final-stage factor of 2^c, from 1 for code 0 up to 128 for code 7.
- R4: Coarse codes 0, 1, 2 and 3 give prescale factors of 1, 3, 4 and 13.
- R5: While the extended register is zero, the strobe period in bus cycles is coarse factor × 16 × 2^code.
- R6: A write to address 1 loads the 8-bit extended register. While that register holds a nonzero value E, the strobe period is coarse factor × 16 × E, whatever the receiver rate code is.
- R7: Writing 0 to the extended register returns the block to the power-of-two path.
- R8: `rate_stb_o` is high for exactly one cycle per period and is never high in two consecutive cycles.
- R9: A write to address 0 or 1 clears every counter and the output strobe. The first new strobe appears N cycles after the write edge, where N is the new period.
- R10: Writes to addresses 2 and 3 change no register and do not disturb the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rate_stb_o | output | 1 | Single-cycle receive rate strobe |

## Verification
The period assertions assume that configuration changes only through the write port and that each mapped write is seen as a restart. The bench therefore drives the write inputs for a single cycle at the falling edge and never holds a write across several cycles. The checker computes the period it expects from the registered configuration, so the stimulus lets every new setting run for several whole periods before it moves on. Unmapped writes are placed in the middle of a period to show that they cause no restart.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int COARSE_W = 2;
  localparam int RXC_W    = 3;
  localparam int EXT_W    = 8;
  localparam int BASE_DIV = 16;
  localparam int PRE_W    = 4;
  localparam int BASE_W   = $clog2(BASE_DIV);
  localparam int POW_W    = (1 << RXC_W) - 1;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_EXT  = 2'd1
  } reg_addr_e;

  typedef struct packed {
    logic [COARSE_W-1:0] coarse;
    logic [RXC_W-1:0]    rxc;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] coarse_lim(input logic [COARSE_W-1:0] code);
    case (code)
      2'd0:    coarse_lim = PRE_W'(0);
      2'd1:    coarse_lim = PRE_W'(2);
      2'd2:    coarse_lim = PRE_W'(3);
      default: coarse_lim = PRE_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/rxr_tc_div.sv
module rxr_tc_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         stb_o
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim = (cnt_q >= lim_i);
  assign stb_o  = en_i && !clr_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= at_lim ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rx_rate_gen.sv
module rx_rate_gen
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rate_stb_o
);
  logic              wr_ctrl, wr_ext, cfg_clr;
  logic [COARSE_W-1:0] coarse_q;
  logic [RXC_W-1:0]  rxc_q;
  logic [EXT_W-1:0]  ext_q;
  logic              ext_on;
  logic              pre_stb, base_stb, pow_stb, ext_stb, sel_stb;
  logic [POW_W-1:0]  pow_lim;
  logic [EXT_W-1:0]  ext_lim;
  ctrl_t             ctrl_wr;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  assign wr_ext  = wr_en_i && (wr_addr_i == ADDR_W'(A_EXT));
  assign cfg_clr = wr_ctrl || wr_ext;
  assign ctrl_wr = ctrl_t'(wr_data_i[COARSE_W+RXC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      rxc_q    <= '0;
      ext_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        coarse_q <= ctrl_wr.coarse;
        rxc_q    <= ctrl_wr.rxc;
      end
      if (wr_ext) ext_q <= wr_data_i[EXT_W-1:0];
    end
  end

  // thermometer limit = 2^code - 1
  always_comb begin
    pow_lim = '0;
    for (int i = 0; i < POW_W; i++) pow_lim[i] = (i < int'(rxc_q));
  end

  assign ext_on  = (ext_q != '0);
  assign ext_lim = ext_q - EXT_W'(1);

  rxr_tc_div #(.W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(cfg_clr), .en_i(1'b1),
    .lim_i(coarse_lim(coarse_q)), .stb_o(pre_stb)
  );

  rxr_tc_div #(.W(BASE_W)) u_base (
    .clk_i, .rst_ni, .clr_i(cfg_clr), .en_i(pre_stb),
    .lim_i(BASE_W'(BASE_DIV - 1)), .stb_o(base_stb)
  );

  rxr_tc_div #(.W(POW_W)) u_pow (
    .clk_i, .rst_ni, .clr_i(cfg_clr), .en_i(base_stb),
    .lim_i(pow_lim), .stb_o(pow_stb)
  );

  rxr_tc_div #(.W(EXT_W)) u_ext (
    .clk_i, .rst_ni, .clr_i(cfg_clr), .en_i(base_stb && ext_on),
    .lim_i(ext_lim), .stb_o(ext_stb)
  );

  assign sel_stb = ext_on ? ext_stb : pow_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_stb_o <= 1'b0;
    else if (cfg_clr) rate_stb_o <= 1'b0;
    else              rate_stb_o <= sel_stb;
  end
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk
  import rxr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [1:0]          wr_addr_i,
  input logic                rate_stb_o,
  input logic [COARSE_W-1:0] coarse_q,
  input logic [RXC_W-1:0]    rxc_q,
  input logic [EXT_W-1:0]    ext_q
);
  logic wr_map;
  int   gap_q;
  int   n_exp;
  int   fac;

  assign wr_map = wr_en_i && (wr_addr_i < 2'd2);

  always_comb begin
    fac   = int'(coarse_lim(coarse_q)) + 1;
    n_exp = (ext_q != '0) ? fac * BASE_DIV * int'(ext_q)
                          : fac * BASE_DIV * (1 << rxc_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= 0;
    else if (wr_map)     gap_q <= 0;
    else if (rate_stb_o) gap_q <= 1;
    else                 gap_q <= gap_q + 1;
  end

  AST_STB_ON_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_stb_o |-> (gap_q == n_exp)); // R5
  AST_NO_MISSED_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q == n_exp) |-> rate_stb_o); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_stb_o |=> !rate_stb_o); // R8
  AST_WR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_map |=> !rate_stb_o); // R9
  AST_UNMAPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_map) |=> ($stable(ext_q) && $stable(coarse_q) && $stable(rxc_q))); // R10
endmodule

bind rx_rate_gen rxr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rate_stb_o(rate_stb_o), .coarse_q(coarse_q), .rxc_q(rxc_q), .ext_q(ext_q)
);

// File: tb/tb_rx_rate_gen.sv
`timescale 1ns/1ps
module tb_rx_rate_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic       rate_stb_o;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state
  int m_coarse = 0, m_rxc = 0, m_ext = 0, k = 0;

  rx_rate_gen dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic int cfac(int c);
    int f[4] = '{1, 3, 4, 13};
    return f[c];
  endfunction

  function automatic int period();
    if (m_ext != 0) return cfac(m_coarse) * 16 * m_ext;
    return cfac(m_coarse) * 16 * (2 ** m_rxc);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_coarse = 0; m_rxc = 0; m_ext = 0; k = 0;
    end else if (wr_en_i && wr_addr_i == 2'd0) begin
      m_rxc = wr_data_i[2:0]; m_coarse = wr_data_i[4:3]; k = 0;
    end else if (wr_en_i && wr_addr_i == 2'd1) begin
      m_ext = wr_data_i; k = 0;
    end else begin
      k++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic e;
      e = (k != 0) && (k % period() == 0);
      checks++;
      if (rate_stb_o !== e) begin
        errors++;
        $display("FAIL %s: k=%0d rate_stb_o=%b expected=%b", cur_req, k, rate_stb_o, e);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    run(4);
    checks++;
    if (rate_stb_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: rate_stb_o in reset=%b expected=0", rate_stb_o);
    end
    rst_ni = 1'b1;
    cur_req = "R1"; run(50);                         // default period 16

    cur_req = "R3";                                  // R5 as well
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 8'(c));
      run(3 * period() + 3);
    end

    cur_req = "R4";
    for (int p = 1; p < 4; p++) begin
      wr(2'd0, 8'((p << 3) | 1));
      run(3 * period() + 3);
    end

    cur_req = "R2";                                  // junk upper bits
    wr(2'd0, 8'hE0 | 8'((2 << 3) | 2));
    run(3 * period() + 3);

    cur_req = "R6";
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd1);   run(3 * period() + 3);
    wr(2'd1, 8'd2);   run(3 * period() + 3);
    wr(2'd1, 8'd255); run(3 * period() + 3);
    wr(2'd0, 8'((1 << 3) | 7));
    wr(2'd1, 8'd5);   run(3 * period() + 3);

    cur_req = "R7";
    wr(2'd1, 8'd0);   run(3 * period() + 3);

    cur_req = "R9";
    wr(2'd0, 8'd2);   run(period() / 2);
    wr(2'd0, 8'd2);   run(period() + period() / 3);
    wr(2'd1, 8'd3);   run(3 * period() + 3);
    wr(2'd1, 8'd0);

    cur_req = "R10";
    run(20);
    wr(2'd2, 8'hFF);  run(10);
    wr(2'd3, 8'h1F);  run(3 * period() + 3);

    cur_req = "R8";
    wr(2'd0, 8'd0);   run(100);

    finish_run();
  end
endmodule